// File: doc/BRIEF.md
# Interleaved Output/Input Port with Serial Transmit Routing

This block is an 8-bit general-purpose port whose pin roles are fixed in hardware. Pins on even bit positions always drive outputs, and pins on odd bit positions are always inputs. It has four output pads and four input pads. A register bus reaches two locations: a data latch and a write-only function register.

Each even pin is driven by either its data-latch bit or one of four serial transmit lines. The function register makes that choice separately for each pin. The serial ports sit outside the block. The odd input pins can be read through the data location at any time, including while an outside serial receiver also uses them.

A read of the data location returns a merged byte. Each odd bit holds the level on its input pad. Each even bit holds the signal that is actually driving the output pad, not the value stored in the latch. Software can therefore see whether a pin currently carries latch data or serial traffic.

Top module: `serial_mux_port`

## Requirements
- R1: After reset the data latch holds 1 in output slots 0, 1 and 2 (byte bits 0, 2, 4) and 0 in slot 3 (byte bit 6), so `pad_out` reads 4'b0111.
- R2: After reset every function bit is 0, so each `pad_out[i]` follows the latch no matter what `ser_txd` does.
- R3: A bus write to location 0 (data) stores byte bit 2i into latch slot i, and `pad_out[i]` shows the new value from the cycle after the write whenever function bit i is 0.
- R4: A write to location 1 (function) stores byte bit 2i as function bit i. While that bit is 1, `pad_out[i]` equals `ser_txd[i]` in the same cycle, and the latch value has no effect on the pin.
- R5: A read asserted with `bus_rd` returns `bus_rdata` with `bus_rvalid` high in the next cycle, and only then. For location 0, bit 2i+1 equals `pad_in[i]` and bit 2i equals `pad_out[i]` as sampled in the cycle of the request.
- R6: A read of location 1 returns 8'h00.
- R7: Odd bits of a write to the function register are ignored: only even bits change the routing.
- R8: Odd bits of a write to the data location are ignored: they change neither the pins nor the readback.
- R9: Writes to the data location still update the latch while a pin is routed to serial. When the function bit is cleared, the pin shows the latest latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register location: 0 data, 1 function |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ser_txd | input | 4 | Serial transmit lines, one per output slot |
| pad_out | output | 4 | Output pads, slot i is byte bit 2i |
| pad_in | input | 4 | Input pads, slot i is byte bit 2i+1 |

## Verification
The bench sets a function bit and toggles the serial line. A design that returned the latch instead of the driving signal would then show a stale even bit on readback, and a design that did not route the pin would hold the pin steady. It writes 0xAA to both locations. A design that decoded odd bits would move the pins or alter the readback. It also updates the latch while a pin is routed to serial and then releases the pin. A design that blocked writes while routed would reveal the old value at that point. Reads of the function location must return zero, and reads after reset must return 0x15 with the input pads low.

// File: rtl/serial_mux_port_pkg.sv
package serial_mux_port_pkg;
    localparam int PAIRS  = 4;
    localparam int BYTE_W = 2 * PAIRS;

    typedef logic [PAIRS-1:0]  slot_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        LOC_DATA = 1'b0,
        LOC_FUNC = 1'b1
    } loc_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        loc_e  loc;
        byte_t wdata;
    } bus_req_t;

    // slot 3 low, slots 2..0 high
    localparam slot_t LATCH_INIT = slot_t'(4'b0111);
    localparam slot_t FUNC_INIT  = '0;

    function automatic slot_t even_slots(input byte_t b);
        slot_t s;
        for (int i = 0; i < PAIRS; i++) s[i] = b[2*i];
        return s;
    endfunction

    function automatic byte_t weave(input slot_t drv, input slot_t pin);
        byte_t b;
        for (int i = 0; i < PAIRS; i++) begin
            b[2*i]   = drv[i];
            b[2*i+1] = pin[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/smp_regs.sv
module smp_regs
    import serial_mux_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output slot_t    latch_q,
    output slot_t    func_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= LATCH_INIT;
            func_q  <= FUNC_INIT;
        end else if (req.wr) begin
            if (req.loc == LOC_DATA) latch_q <= even_slots(req.wdata);
            else                     func_q  <= even_slots(req.wdata);
        end
    end

    // R7
    func_even_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.loc == LOC_FUNC) |=> (func_q == $past(even_slots(req.wdata))));

    // R9
    latch_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.loc == LOC_FUNC) |=> $stable(latch_q));
endmodule

// File: rtl/smp_drive.sv
module smp_drive
    import serial_mux_port_pkg::*;
(
    input  slot_t latch_q,
    input  slot_t func_q,
    input  slot_t ser_txd,
    output slot_t drive
);
    for (genvar i = 0; i < PAIRS; i++) begin : g_pin
        always_comb drive[i] = func_q[i] ? ser_txd[i] : latch_q[i];
    end
endmodule

// File: rtl/smp_readback.sv
module smp_readback
    import serial_mux_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  slot_t    drive,
    input  slot_t    pin,
    output byte_t    rdata,
    output logic     rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= req.rd;
            if (req.rd)
                rdata <= (req.loc == LOC_DATA) ? weave(drive, pin) : '0;
        end
    end

    // R5
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req.rd |=> rvalid);

    // R5
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> !rvalid);

    // R6
    func_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.loc == LOC_FUNC) |=> (rdata == '0));

    // R5
    odd_pin_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.loc == LOC_DATA) |=> (rdata[1] == $past(pin[0]) && rdata[7] == $past(pin[3])));
endmodule

// File: rtl/serial_mux_port.sv
module serial_mux_port
    import serial_mux_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [PAIRS-1:0]  ser_txd,
    output logic [PAIRS-1:0]  pad_out,
    input  logic [PAIRS-1:0]  pad_in
);
    bus_req_t req;
    slot_t    latch_q, func_q, drive;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.loc   = loc_e'(bus_sel);
        req.wdata = bus_wdata;
    end

    smp_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .latch_q(latch_q), .func_q(func_q)
    );

    smp_drive u_drive (
        .latch_q(latch_q), .func_q(func_q), .ser_txd(ser_txd), .drive(drive)
    );

    smp_readback u_rb (
        .clk(clk), .rst(rst), .req(req), .drive(drive), .pin(pad_in),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    assign pad_out = drive;

    // R3
    data_to_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel && func_q == '0) |=> (pad_out == $past(even_slots(bus_wdata))));

    // R2
    idle_func_chk: assert property (@(posedge clk) disable iff (rst)
        (func_q == '0) |-> (pad_out == latch_q));
endmodule

// File: tb/tb_serial_mux_port.sv
module tb_serial_mux_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [3:0] ser_txd = 4'h0, pad_out, pad_in = 4'h0;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] m_latch = 4'b0111, m_func = 4'h0;

    always #2 clk = ~clk;

    serial_mux_port dut (.*);

    function automatic logic [7:0] mix(input logic [3:0] d, input logic [3:0] p);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin b[2*i] = d[i]; b[2*i+1] = p[i]; end
        return b;
    endfunction

    function automatic logic [3:0] evens(input logic [7:0] b);
        return {b[6], b[4], b[2], b[0]};
    endfunction

    function automatic logic [3:0] model_out();
        return (m_func & ser_txd) | (~m_func & m_latch);
    endfunction

    task automatic tally(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pins(input string tag);
        #1 tally(tag, {4'h0, pad_out}, {4'h0, model_out()});
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (sel) m_func = evens(d); else m_latch = evens(d);
    endtask

    task automatic rd(input logic sel, input string tag);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        exp_q.push_back(sel ? 8'h00 : mix(model_out(), pad_in));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: pops expected read data when the design presents it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                tally(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset latch and R2 function cleared
        pins("R1 reset pins");
        ser_txd = 4'hF; pins("R2 ser ignored after reset");
        rd(1'b0, "R1 reset readback");
        @(negedge clk);
        tally("R5 rvalid low when idle", {7'h0, bus_rvalid}, 8'h00);
        pad_in = 4'b1010;
        rd(1'b0, "R5 odd bits from pads");
        // R3 data write
        wr(1'b0, 8'h41); pins("R3 write 41");
        wr(1'b0, 8'h14); pins("R3 write 14");
        pad_in = 4'b0101;
        rd(1'b0, "R3 readback");
        // R8 odd data bits ignored
        wr(1'b0, 8'hAA); pins("R8 odd data bits");
        rd(1'b0, "R8 readback");
        // R7 odd function bits ignored
        wr(1'b1, 8'hAA); ser_txd = 4'h0; pins("R7 odd func bits");
        wr(1'b0, 8'h55); pins("R7 latch still drives");
        // R4 route slots 0 and 2 to serial
        wr(1'b1, 8'h11);
        ser_txd = 4'b0000; pins("R4 serial low");
        ser_txd = 4'b0101; pins("R4 serial high");
        ser_txd = 4'b1010; pins("R4 unrouted slots ignore serial");
        rd(1'b0, "R4 readback shows drive");
        rd(1'b1, "R6 func reads zero");
        // R9 latch update while routed, then release
        wr(1'b0, 8'h00); ser_txd = 4'b0101; pins("R9 routed pins hold serial");
        wr(1'b1, 8'h00); pins("R9 released pins show new latch");
        rd(1'b0, "R9 readback");
        // back-to-back reads
        pad_in = 4'b1111;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b1;
        exp_q.push_back(mix(model_out(), pad_in)); tag_q.push_back("R5 back-to-back 1");
        @(negedge clk);
        bus_sel = 1'b1;
        exp_q.push_back(8'h00); tag_q.push_back("R6 back-to-back 2");
        @(negedge clk);
        bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        tally("R5 all reads returned", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule